// File: doc/BRIEF.md
# Distributed-Arithmetic Pattern Correlator

This block watches a stream of signed samples for a known reference waveform. Each accepted sample produces one correlation value. That value is the dot product of the reference with the most recent window of samples, lined up so that the oldest sample in the window meets the first reference value. The block computes it as a transversal filter whose taps carry the reference back to front. The newest sample therefore meets the last reference value.

No multiplier is used. The taps are split into sets of four. For each set, a 16-entry table holds every possible sum of that set's coefficients, and one bit of each of the four samples addresses the table. The table outputs for all bit planes are added together with binary weights in a single cycle. The plane that carries the sign bit is subtracted, which gives exact two's-complement products at the rate of one result per sample.

Coefficients are written one at a time through a small load port, and writing one rebuilds the tables. A threshold comparison gives a one-cycle match flag beside each valid result.

Top module: `dacorr_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `out_valid` and `out_match` are 0 and `out_corr` is 0.
- R2: A valid result equals the sum over j = 0..N-1 of ref[j] · x[n-N+1+j]. Here ref[j] is the value last written with `cfg_sel` = j, x[n] is the newest accepted sample, and samples and coefficients are two's complement.
- R3: `out_valid` is a one-cycle pulse. It is registered and appears in the second rising edge after the edge that accepted the sample, and it is high in no other cycle.
- R4: After reset, or after any coefficient write with `cfg_sel` < N, no result is marked valid until N further samples have been accepted. The N-th of them gives the first valid result.
- R5: A cycle with `in_valid` low neither shifts the sample window nor produces a valid result.
- R6: The result width is SW+CW+ceil(log2 N) bits, and the full range holds without wrap. For N=40 and 8-bit operands, all samples -128 with all coefficients -128 give 655360, and the same samples with all coefficients 127 give -650240.
- R7: `out_match` is 1 exactly when `out_valid` is 1 and `out_corr` ≥ `thresh`, as signed values, with `thresh` sampled on the same edge as the result. Equality counts as a match.
- R8: Samples presented on consecutive cycles each produce a correct valid result on consecutive cycles.
- R9: A coefficient write with `cfg_sel` ≥ N changes no coefficient and does not restart the fill count of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | SW | Signed input sample |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | ceil(log2(N+1)) | Reference index of the coefficient being written |
| cfg_coef | input | CW | Signed coefficient value |
| thresh | input | SW+CW+ceil(log2 N) | Signed match threshold |
| out_valid | output | 1 | Result strobe |
| out_corr | output | SW+CW+ceil(log2 N) | Signed correlation result |
| out_match | output | 1 | Result at or above threshold |

## Verification
Some properties hold on every cycle, and the assertions check those. A valid result is always tied back to an accepted sample two edges earlier. The match flag never rises without a valid result, and a valid result that does not match lies below the threshold. Results stay inside the product bound. An idle cycle leaves the sample window untouched, and a coefficient write suppresses validity. Only the bench scenarios can show that the numbers are right: the arithmetic value of each result, the reversed tap order, the exact cycle at which results become valid after a fill, and that a copy of the reference buried in noise peaks at the aligned sample.

// File: rtl/dacorr_pkg.sv
package dacorr_pkg;

   // Width of one table entry: a sum of GROUP signed CW-bit coefficients.
   function automatic int lut_width(input int cw, input int group);
      return cw + $clog2(group) + 1;
   endfunction

   // Largest magnitude a correlation result can reach.
   function automatic longint mag_limit(input int n, input int sw, input int cw);
      return longint'(n) * (longint'(1) <<< (sw - 1)) * (longint'(1) <<< (cw - 1));
   endfunction

endpackage

// File: rtl/dacorr_tapline.sv
module dacorr_tapline #(
   parameter int NPAD = 40,
   parameter int SW   = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 shift,
   input  logic [SW-1:0]        din,
   output logic [NPAD*SW-1:0]   taps
);

   logic [NPAD*SW-1:0] taps_q;

   // Newest sample sits in the lowest slot; the window moves only on shift.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         taps_q <= '0;
      else if (shift)
         taps_q <= {taps_q[(NPAD-1)*SW-1:0], din};
   end

   assign taps = taps_q;

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !shift |=> $stable(taps_q)); // R5

   AST_NEWEST_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
      shift |=> (taps_q[SW-1:0] == $past(din))); // R2

endmodule

// File: rtl/dacorr_lutbank.sv
module dacorr_lutbank #(
   parameter int NTAPS   = 40,
   parameter int NPAD    = 40,
   parameter int GROUP   = 4,
   parameter int CW      = 8,
   parameter int LW      = 11,
   parameter int SELW    = 6,
   parameter bit LUT_REG = 1'b1,
   localparam int NGRP  = NPAD / GROUP,
   localparam int DEPTH = 1 << GROUP
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [SELW-1:0]           cfg_sel,
   input  logic [CW-1:0]             cfg_coef,
   output logic                      wr_hit,
   output logic [NGRP*DEPTH*LW-1:0]  lut_flat
);

   logic signed [CW-1:0] coef_q [NPAD];

   assign wr_hit = cfg_we && (cfg_sel < SELW'(NTAPS));

   // Reference index j is stored at tap NTAPS-1-j; pad taps stay zero.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NPAD; k++) coef_q[k] <= '0;
      end else begin
         for (int k = 0; k < NTAPS; k++)
            if (wr_hit && (cfg_sel == SELW'(NTAPS - 1 - k)))
               coef_q[k] <= cfg_coef;
      end
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      for (genvar a = 0; a < DEPTH; a++) begin : g_ent
         logic signed [LW-1:0] ent_d;
         always_comb begin
            ent_d = '0;
            for (int i = 0; i < GROUP; i++)
               if (((a >> i) & 1) != 0)
                  ent_d = ent_d + LW'(coef_q[g*GROUP + i]);
         end
         if (LUT_REG) begin : g_reg
            logic signed [LW-1:0] ent_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) ent_q <= '0;
               else        ent_q <= ent_d;
            end
            assign lut_flat[(g*DEPTH + a)*LW +: LW] = ent_q;
         end else begin : g_comb
            assign lut_flat[(g*DEPTH + a)*LW +: LW] = ent_d;
         end
      end
   end

endmodule

// File: rtl/dacorr_bitsum.sv
module dacorr_bitsum #(
   parameter int NPAD  = 40,
   parameter int GROUP = 4,
   parameter int SW    = 8,
   parameter int LW    = 11,
   parameter int ACCW  = 22,
   localparam int NGRP  = NPAD / GROUP,
   localparam int DEPTH = 1 << GROUP
) (
   input  logic [NPAD*SW-1:0]        taps,
   input  logic [NGRP*DEPTH*LW-1:0]  lut_flat,
   output logic signed [ACCW-1:0]    da_sum
);

   logic signed [ACCW-1:0] plane;
   logic [GROUP-1:0]       addr;

   // One bit plane per sample bit; the sign plane carries negative weight.
   always_comb begin
      da_sum = '0;
      plane  = '0;
      addr   = '0;
      for (int b = 0; b < SW; b++) begin
         plane = '0;
         for (int g = 0; g < NGRP; g++) begin
            for (int i = 0; i < GROUP; i++)
               addr[i] = taps[(g*GROUP + i)*SW + b];
            plane = plane + ACCW'($signed(lut_flat[(g*DEPTH + int'(addr))*LW +: LW]));
         end
         if (b == SW - 1) da_sum = da_sum - (plane <<< b);
         else             da_sum = da_sum + (plane <<< b);
      end
   end

endmodule

// File: rtl/dacorr_top.sv
module dacorr_top
   import dacorr_pkg::*;
#(
   parameter int NTAPS   = 40,
   parameter int SW      = 8,
   parameter int CW      = 8,
   parameter int GROUP   = 4,
   parameter bit LUT_REG = 1'b1,
   localparam int ACCW = SW + CW + $clog2(NTAPS),
   localparam int SELW = $clog2(NTAPS + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [SW-1:0]          in_sample,
   input  logic                   cfg_we,
   input  logic [SELW-1:0]        cfg_sel,
   input  logic [CW-1:0]          cfg_coef,
   input  logic signed [ACCW-1:0] thresh,
   output logic                   out_valid,
   output logic signed [ACCW-1:0] out_corr,
   output logic                   out_match
);

   localparam int NGRP  = (NTAPS + GROUP - 1) / GROUP;
   localparam int NPAD  = NGRP * GROUP;
   localparam int DEPTH = 1 << GROUP;
   localparam int LW    = lut_width(CW, GROUP);
   localparam longint LIM = mag_limit(NTAPS, SW, CW);

   if (GROUP < 2 || GROUP > 6) begin : g_bad_group
      $error("GROUP must lie in 2..6");
   end
   if (NTAPS < GROUP) begin : g_bad_taps
      $error("NTAPS must be at least GROUP");
   end
   if (SW < 2 || CW < 2) begin : g_bad_width
      $error("operand widths must be at least 2");
   end

   logic [NPAD*SW-1:0]       taps;
   logic [NGRP*DEPTH*LW-1:0] lut_flat;
   logic signed [ACCW-1:0]   da_sum;
   logic                     wr_hit;
   logic [SELW-1:0]          fill_q;
   logic                     acc_q;
   logic                     filled;

   dacorr_tapline #(.NPAD(NPAD), .SW(SW)) u_tapline (
      .clk(clk), .rst_n(rst_n), .shift(in_valid), .din(in_sample), .taps(taps));

   dacorr_lutbank #(.NTAPS(NTAPS), .NPAD(NPAD), .GROUP(GROUP), .CW(CW), .LW(LW),
                    .SELW(SELW), .LUT_REG(LUT_REG)) u_lutbank (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_coef(cfg_coef), .wr_hit(wr_hit), .lut_flat(lut_flat));

   dacorr_bitsum #(.NPAD(NPAD), .GROUP(GROUP), .SW(SW), .LW(LW), .ACCW(ACCW)) u_bitsum (
      .taps(taps), .lut_flat(lut_flat), .da_sum(da_sum));

   assign filled = (fill_q == SELW'(NTAPS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q    <= '0;
         acc_q     <= 1'b0;
         out_valid <= 1'b0;
         out_match <= 1'b0;
         out_corr  <= '0;
      end else begin
         acc_q <= in_valid;
         if (wr_hit)
            fill_q <= '0;
         else if (in_valid && !filled)
            fill_q <= fill_q + 1'b1;
         out_valid <= acc_q && filled;
         out_match <= acc_q && filled && (da_sum >= thresh);
         if (acc_q)
            out_corr <= da_sum;
      end
   end

   AST_VALID_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2)); // R3

   AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (cfg_sel < SELW'(NTAPS))) |-> ##2 !out_valid); // R4

   AST_MATCH_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_match |-> out_valid); // R7

   AST_MISS_BELOW_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_match) |-> (out_corr < $past(thresh))); // R7

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((longint'(out_corr) <= LIM) && (longint'(out_corr) >= -LIM))); // R6

endmodule

// File: tb/test_dacorr_top.sv
module test_dacorr_top;
   localparam int N    = 40;
   localparam int SW   = 8;
   localparam int CW   = 8;
   localparam int ACCW = SW + CW + $clog2(N);
   localparam int SELW = $clog2(N + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [SW-1:0] in_sample = '0;
   logic cfg_we = 1'b0;
   logic [SELW-1:0] cfg_sel = '0;
   logic [CW-1:0] cfg_coef = '0;
   logic signed [ACCW-1:0] thresh = '0;
   logic out_valid, out_match;
   logic signed [ACCW-1:0] out_corr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int ref_m [N];
   int hist [N];
   int seen = 0;
   longint thr_m = 0;

   always #5 clk = ~clk;

   dacorr_top i_dacorr_top (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_coef(cfg_coef), .thresh(thresh),
      .out_valid(out_valid), .out_corr(out_corr), .out_match(out_match));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint model();
      longint s = 0;
      for (int j = 0; j < N; j++) s += longint'(ref_m[j]) * longint'(hist[N-1-j]);
      return s;
   endfunction

   task automatic shift_model(input int s);
      for (int k = N - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = s;
      if (seen < N) seen++;
   endtask

   task automatic check_exp(input string req, input bit v, input longint e);
      if (v) begin
         chk(out_valid == 1'b1, req, longint'(out_valid), 1);
         chk(longint'(out_corr) == e, req, longint'(out_corr), e);
         chk(out_match == (e >= thr_m), "R7", longint'(out_match), longint'(e >= thr_m));
      end else begin
         chk(out_valid == 1'b0, req, longint'(out_valid), 0);
         chk(out_match == 1'b0, "R7", longint'(out_match), 0);
      end
   endtask

   task automatic push(input int s, input string req);
      in_sample = SW'(s);
      in_valid  = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      shift_model(s);
      @(negedge clk);
      check_exp(req, seen >= N, model());
   endtask

   task automatic push2(input int a, input int b);
      longint ea;
      bit va;
      in_sample = SW'(a);
      in_valid  = 1'b1;
      @(negedge clk);
      in_sample = SW'(b);
      shift_model(a);
      ea = model();
      va = (seen >= N);
      @(negedge clk);
      in_valid = 1'b0;
      check_exp("R8", va, ea);
      shift_model(b);
      @(negedge clk);
      check_exp("R8", seen >= N, model());
   endtask

   task automatic idle(input int k, input string req);
      for (int i = 0; i < k; i++) begin
         @(negedge clk);
         chk(out_valid == 1'b0, req, longint'(out_valid), 0);
      end
   endtask

   task automatic cfg(input int idx, input int val);
      cfg_we   = 1'b1;
      cfg_sel  = SELW'(idx);
      cfg_coef = CW'(val);
      @(negedge clk);
      cfg_we = 1'b0;
      if (idx < N) begin
         ref_m[idx] = val;
         seen = 0;
      end
      @(negedge clk);
      chk(out_valid == 1'b0, "R4", longint'(out_valid), 0);
   endtask

   task automatic set_thr(input longint v);
      thresh = ACCW'(v);
      thr_m  = v;
   endtask

   function automatic int rnd_sample();
      return int'($urandom_range(0, 255)) - 128;
   endfunction

   initial begin
      longint peak;
      for (int j = 0; j < N; j++) begin ref_m[j] = 0; hist[j] = 0; end
      set_thr(0);
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0 && out_match == 1'b0, "R1", longint'(out_valid), 0);
      chk(out_corr == '0, "R1", longint'(out_corr), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0 && out_corr == '0, "R1", longint'(out_corr), 0);

      // Load the reference; R4 fill gating then the first valid result.
      for (int j = 0; j < N; j++) cfg(j, ((j * 37 + 11) % 255) - 127);
      for (int i = 0; i < N; i++) push(rnd_sample(), (i < N - 1) ? "R4" : "R2");
      idle(1, "R3");

      // Random stream with idle gaps: R2, R5, R7 at threshold 0.
      for (int i = 0; i < 150; i++) begin
         push(rnd_sample(), "R2");
         if (i % 7 == 3) idle(int'($urandom_range(1, 3)), "R5");
      end

      // Back-to-back samples.
      for (int i = 0; i < 20; i++) push2(rnd_sample(), rnd_sample());

      // Reference buried in small noise at a random offset.
      peak = 0;
      for (int j = 0; j < N; j++) peak += longint'(ref_m[j]) * longint'(ref_m[j]);
      set_thr(peak);
      for (int i = 0; i < N + int'($urandom_range(0, 20)); i++)
         push(int'($urandom_range(0, 16)) - 8, "R2");
      for (int j = 0; j < N; j++) push(ref_m[j], "R2");
      chk(longint'(out_corr) == peak, "R2", longint'(out_corr), peak);
      chk(out_match == 1'b1, "R7", longint'(out_match), 1);
      set_thr(peak + 1);
      for (int i = 0; i < 5; i++) push(int'($urandom_range(0, 16)) - 8, "R2");
      for (int j = 0; j < N; j++) push(ref_m[j], "R2");
      chk(out_match == 1'b0, "R7", longint'(out_match), 0);
      set_thr(0);

      // Out-of-range index: no coefficient change, no fill restart.
      cfg_we = 1'b1; cfg_sel = SELW'(N); cfg_coef = CW'(55);
      @(negedge clk);
      cfg_we = 1'b0;
      push(rnd_sample(), "R9");
      chk(out_valid == 1'b1, "R9", longint'(out_valid), 1);
      cfg_we = 1'b1; cfg_sel = SELW'((1 << SELW) - 1); cfg_coef = CW'(-90);
      @(negedge clk);
      cfg_we = 1'b0;
      push(rnd_sample(), "R9");

      // Mid-stream reload restarts the fill.
      cfg(5, -100);
      for (int i = 0; i < N; i++) push(rnd_sample(), (i < N - 1) ? "R4" : "R2");

      // Extremes of the signed range.
      for (int j = 0; j < N; j++) cfg(j, -128);
      for (int i = 0; i < N; i++) push(-128, "R6");
      chk(longint'(out_corr) == 655360, "R6", longint'(out_corr), 655360);
      for (int j = 0; j < N; j++) cfg(j, 127);
      for (int i = 0; i < N; i++) push(-128, "R6");
      chk(longint'(out_corr) == -650240, "R6", longint'(out_corr), -650240);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R3 watchdog expired actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule